// File: doc/BRIEF.md
# Saturating Rounding Variable Shifter

This block is a single-element shift datapath. One element, taken from the low bits of a 64-bit operand, is shifted by a signed amount. A positive amount shifts left and a negative amount shifts right. The element width can be 8, 16, 32 or 64 bits. Three interpretations are supported: signed in and signed out, unsigned in and unsigned out, and signed in with an unsigned result.

Two enables control the shift independently. The first rounds right shifts to nearest. The second clamps left shifts that overflow the element to the representable limit. The shifted element and a saturation indication are produced combinationally. The indication is also collected into a sticky flag, which a clear input resets.

The block is meant to sit inside a vector lane. Decode, lane packing and predication happen outside it.

Top module: `vsh_lane`

## Requirements
- R1: `width_i` selects the element width: 0 selects 8 bits, 1 selects 16, 2 selects 32 and 3 selects 64. Only the low width bits of `elem_i` are used. Result bits at and above the width are 0.
- R2: `mode_i` 0 is signed, 1 is unsigned, 2 is signed input to unsigned result, and 3 behaves as 1. A left shift by k below the width whose true result fits the element returns that result with no flag. For signed, the result fits when it lies between -2^(W-1) and 2^(W-1)-1. For unsigned, it fits when it is below 2^W.
- R3: Without rounding, a negative amount -n shifts right by n. The shift is arithmetic in signed mode and logical otherwise. When n is at least the width, the result is all sign bits in signed mode and 0 otherwise.
- R4: With rounding, a right shift by n returns floor(x/2^(n-1)) shifted right once more, plus the low bit of floor(x/2^(n-1)). In signed mode, n of at least W gives 0. In the other modes, n of at least W+1 gives 0, and n equal to W gives the top element bit.
- R5: With saturation off, an overflowing left shift below the width returns the truncated low W bits. A left shift of W or more returns 0. Neither sets the flag.
- R6: In signed mode with saturation on, an overflowing left shift returns 2^(W-1)-1 for a non-negative source and -2^(W-1) for a negative source, and sets `sat_o`. A shift of W or more overflows whenever the source is non-zero. A zero source gives 0 with no flag.
- R7: In unsigned mode with saturation on, an overflowing left shift returns all ones across the width and sets `sat_o`.
- R8: In mode 2 with saturation on, a source whose element sign bit is set gives 0 and sets `sat_o` for any amount. Otherwise mode 2 behaves as mode 1 on the element bits.
- R9: `shamt_i` is an 8-bit two's-complement amount, -128 to +127, for every width.
- R10: `sticky_o` is 0 after reset. After each clock it equals its old value ANDed with the inverse of `sticky_clr_i`, then ORed with `sat_o`. A flag raised in the same cycle as a clear therefore wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Interpretation: 0 signed, 1 unsigned, 2 signed to unsigned, 3 unsigned |
| width_i | input | 2 | Element width code: 8 << width_i bits |
| round_en_i | input | 1 | Round right shifts to nearest |
| sat_en_i | input | 1 | Saturate on overflow |
| elem_i | input | 64 | Source element in the low bits |
| shamt_i | input | 8 | Signed shift amount |
| sticky_clr_i | input | 1 | Clears the sticky flag at the next clock |
| result_o | output | 64 | Shifted element, zero above the width |
| sat_o | output | 1 | Saturation occurred on this input |
| sticky_o | output | 1 | Accumulated saturation flag |

## Verification
The bench drives shift amounts right at and around the element width in both directions. An off-by-one boundary there shows up as a leftover sign bit, a stray rounding bit, or a missed saturation. Signed left shifts that land exactly on the most negative value must not be flagged. A bound check that is one too tight would clamp them by mistake.

Mode 2 with negative sources is driven with saturation both on and off. The -128 amount is driven to catch a magnitude that wraps to zero during negation. A clear arriving in the same cycle as a flag shows whether the sticky register lets the clear win wrongly.

// File: rtl/vsh_pkg.sv
package vsh_pkg;
  typedef enum logic [1:0] {
    MD_SS  = 2'd0,
    MD_UU  = 2'd1,
    MD_SU  = 2'd2,
    MD_UU2 = 2'd3
  } vsh_mode_e;
endpackage

// File: rtl/vsh_operand.sv
module vsh_operand #(
  parameter int DATA_W = 64,
  parameter int EXT_W  = DATA_W + 2,
  parameter int WS_W   = 2,
  parameter int WW     = $clog2(DATA_W) + 1
) (
  input  logic [DATA_W-1:0]       src_i,
  input  logic [WS_W-1:0]         wsel_i,
  input  logic                    is_signed_i,
  output logic signed [EXT_W-1:0] ext_o,
  output logic                    neg_o,
  output logic                    nz_o,
  output logic [WW-1:0]           w_o,
  output logic [DATA_W-1:0]       mask_o
);
  localparam int NUM_W = $clog2(DATA_W / 8) + 1;

  logic [EXT_W-1:0] cand [NUM_W];
  logic [NUM_W-1:0] cneg;
  logic [NUM_W-1:0] cnz;

  for (genvar g = 0; g < NUM_W; g++) begin : g_width
    localparam int LW = 8 << g;
    assign cneg[g] = src_i[LW-1];
    assign cnz[g]  = |src_i[LW-1:0];
    assign cand[g] = {{(EXT_W-LW){src_i[LW-1] & is_signed_i}}, src_i[LW-1:0]};
  end

  always_comb begin
    ext_o  = $signed(cand[wsel_i]);
    neg_o  = cneg[wsel_i];
    nz_o   = cnz[wsel_i];
    w_o    = WW'(8) << wsel_i;
    mask_o = {DATA_W{1'b1}} >> (DATA_W - int'(w_o));
  end
endmodule

// File: rtl/vsh_right.sv
module vsh_right #(
  parameter int EXT_W = 66,
  parameter int SH_W  = 8
) (
  input  logic signed [EXT_W-1:0] ext_i,
  input  logic [SH_W-1:0]         mag_i,
  input  logic                    rnd_i,
  output logic signed [EXT_W-1:0] val_o
);
  logic [SH_W-1:0]         sa;
  logic signed [EXT_W-1:0] part;

  always_comb begin
    // rounding stops one place early and folds the dropped bit back in
    sa    = rnd_i ? mag_i - SH_W'(1) : mag_i;
    part  = ext_i >>> sa;
    val_o = rnd_i ? (part >>> 1) + $signed({{(EXT_W-1){1'b0}}, part[0]}) : part;
  end
endmodule

// File: rtl/vsh_left.sv
module vsh_left #(
  parameter int DATA_W = 64,
  parameter int EXT_W  = DATA_W + 2,
  parameter int SH_W   = 8,
  parameter int WW     = $clog2(DATA_W) + 1
) (
  input  logic signed [EXT_W-1:0] ext_i,
  input  logic [SH_W-2:0]         k_i,
  input  logic [WW-1:0]           w_i,
  input  logic                    nz_i,
  input  logic                    is_signed_i,
  output logic [DATA_W-1:0]       val_o,
  output logic                    ovf_o
);
  localparam int PW = EXT_W + DATA_W;

  logic signed [PW-1:0] prod;
  logic signed [PW-1:0] hi;
  logic                 beyond;
  logic                 unused_hi;

  always_comb begin
    beyond = int'(k_i) >= int'(w_i);
    prod   = $signed({{DATA_W{ext_i[EXT_W-1]}}, ext_i}) <<< k_i;
    hi     = prod >>> (is_signed_i ? int'(w_i) - 1 : int'(w_i));
    if (beyond) begin
      val_o = '0;
      ovf_o = nz_i;
    end else begin
      val_o = prod[DATA_W-1:0];
      ovf_o = !((hi == '0) || (hi == '1));
    end
  end

  assign unused_hi = ^prod[PW-1:DATA_W];
endmodule

// File: rtl/vsh_lane.sv
module vsh_lane
  import vsh_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int SH_W   = 8,
  parameter int WS_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_i,
  input  logic [WS_W-1:0]   width_i,
  input  logic              round_en_i,
  input  logic              sat_en_i,
  input  logic [DATA_W-1:0] elem_i,
  input  logic [SH_W-1:0]   shamt_i,
  input  logic              sticky_clr_i,
  output logic [DATA_W-1:0] result_o,
  output logic              sat_o,
  output logic              sticky_o
);
  localparam int EXT_W = DATA_W + 2;
  localparam int WW    = $clog2(DATA_W) + 1;

  logic                    is_signed;
  logic                    go_right;
  logic [SH_W-1:0]         mag;
  logic signed [EXT_W-1:0] ext;
  logic                    neg;
  logic                    nz;
  logic [WW-1:0]           w;
  logic [DATA_W-1:0]       mask;
  logic signed [EXT_W-1:0] rval;
  logic [DATA_W-1:0]       lval;
  logic                    lovf;
  logic [DATA_W-1:0]       limit;
  logic                    sticky_q, sticky_d, sticky_en;
  logic                    unused_r;

  assign is_signed = vsh_mode_e'(mode_i) == MD_SS;
  assign go_right  = shamt_i[SH_W-1];
  assign mag       = ~shamt_i + SH_W'(1);

  vsh_operand #(.DATA_W(DATA_W), .EXT_W(EXT_W), .WS_W(WS_W), .WW(WW)) u_opnd (
    .src_i(elem_i), .wsel_i(width_i), .is_signed_i(is_signed),
    .ext_o(ext), .neg_o(neg), .nz_o(nz), .w_o(w), .mask_o(mask)
  );

  vsh_right #(.EXT_W(EXT_W), .SH_W(SH_W)) u_right (
    .ext_i(ext), .mag_i(mag), .rnd_i(round_en_i), .val_o(rval)
  );

  vsh_left #(.DATA_W(DATA_W), .EXT_W(EXT_W), .SH_W(SH_W), .WW(WW)) u_left (
    .ext_i(ext), .k_i(shamt_i[SH_W-2:0]), .w_i(w), .nz_i(nz),
    .is_signed_i(is_signed), .val_o(lval), .ovf_o(lovf)
  );

  assign unused_r = ^rval[EXT_W-1:DATA_W];

  always_comb begin
    if (is_signed) limit = neg ? (mask ^ (mask >> 1)) : (mask >> 1);
    else           limit = mask;
    if ((vsh_mode_e'(mode_i) == MD_SU) && sat_en_i && neg) begin
      result_o = '0;
      sat_o    = 1'b1;
    end else if (!go_right && lovf && sat_en_i) begin
      result_o = limit;
      sat_o    = 1'b1;
    end else begin
      result_o = (go_right ? rval[DATA_W-1:0] : lval) & mask;
      sat_o    = 1'b0;
    end
  end

  assign sticky_en = sat_o | sticky_clr_i;

  always_comb begin
    sticky_d = sticky_q;
    if (sticky_en) sticky_d = (sticky_q & ~sticky_clr_i) | sat_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sticky_q <= 1'b0;
    else        sticky_q <= sticky_d;
  end

  assign sticky_o = sticky_q;
endmodule

// File: rtl/vsh_lane_chk.sv
module vsh_lane_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  mode_i,
  input logic [1:0]  width_i,
  input logic        sat_en_i,
  input logic [63:0] elem_i,
  input logic [7:0]  shamt_i,
  input logic        sticky_clr_i,
  input logic [63:0] result_o,
  input logic        sat_o,
  input logic        sticky_o
);
  logic [63:0] wmask;
  logic        sgn;

  always_comb begin
    case (width_i)
      2'd0:    wmask = 64'hFF;
      2'd1:    wmask = 64'hFFFF;
      2'd2:    wmask = 64'hFFFF_FFFF;
      default: wmask = '1;
    endcase
    sgn = elem_i[(8 << width_i) - 1];
  end

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (result_o & ~wmask) == 64'd0); // R1

  AST_FLAG_NEEDS_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    sat_o |-> sat_en_i); // R6

  AST_UNS_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'd1 && sat_o) |-> (result_o == wmask)); // R7

  AST_SU_NEG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'd2 && sat_en_i && sgn) |-> (result_o == 64'd0 && sat_o)); // R8

  AST_STICKY_SET: assert property (@(posedge clk) disable iff (!rst_n)
    sat_o |=> sticky_o); // R10

  AST_STICKY_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (sticky_clr_i && !sat_o) |=> !sticky_o); // R10

  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!sticky_clr_i && !sat_o) |=> $stable(sticky_o)); // R10

  AST_LEFT_ONLY_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_o && shamt_i[7]) |-> (mode_i == 2'd2 && sgn)); // R9
endmodule

bind vsh_lane vsh_lane_chk chk_i (
  .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .width_i(width_i),
  .sat_en_i(sat_en_i), .elem_i(elem_i), .shamt_i(shamt_i),
  .sticky_clr_i(sticky_clr_i), .result_o(result_o), .sat_o(sat_o),
  .sticky_o(sticky_o)
);

// File: tb/vsh_lane_tb_top.sv
`timescale 1ns/1ps
module vsh_lane_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode_i = '0;
  logic [1:0]  width_i = '0;
  logic        round_en_i = 1'b0;
  logic        sat_en_i = 1'b0;
  logic [63:0] elem_i = '0;
  logic [7:0]  shamt_i = '0;
  logic        sticky_clr_i = 1'b0;
  logic [63:0] result_o;
  logic        sat_o;
  logic        sticky_o;

  int checks = 0;
  int errors = 0;
  bit exp_sticky = 1'b0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  vsh_lane dut_i (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .width_i(width_i),
    .round_en_i(round_en_i), .sat_en_i(sat_en_i), .elem_i(elem_i),
    .shamt_i(shamt_i), .sticky_clr_i(sticky_clr_i), .result_o(result_o),
    .sat_o(sat_o), .sticky_o(sticky_o)
  );

  function automatic void model(input int md, input int ws, input bit rn, input bit st,
                                input logic [63:0] s, input int sh,
                                output logic [63:0] r, output bit f);
    int w = 8 << ws;
    bit sg = (md == 0);
    bit neg = s[w-1];
    logic [63:0] m = (w == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << w) - 64'd1);
    logic [63:0] lim;
    logic signed [129:0] v, t, bnd;
    bit ok;
    int n;
    v = '0;
    for (int i = 0; i < w; i++) v[i] = s[i];
    if (sg && neg) for (int i = w; i < 130; i++) v[i] = 1'b1;
    lim = sg ? (neg ? (m ^ (m >> 1)) : (m >> 1)) : m;
    f = 1'b0;
    r = '0;
    if (md == 2 && st && neg) begin
      f = 1'b1;
    end else if (sh < 0) begin
      n = -sh;
      if (sg) begin
        if (n >= w) t = rn ? '0 : (neg ? '1 : '0);
        else if (rn) begin t = v >>> (n - 1); t = (t >>> 1) + (t & 130'sd1); end
        else t = v >>> n;
      end else begin
        if (n >= w + int'(rn)) t = '0;
        else if (rn) begin t = v >> (n - 1); t = (t >> 1) + (t & 130'sd1); end
        else t = v >> n;
      end
      r = t[63:0] & m;
    end else if (sh < w) begin
      t = v <<< sh;
      if (sg) begin
        bnd = 130'sd1 <<< (w - 1);
        ok = (t >= -bnd) && (t < bnd);
      end else begin
        bnd = 130'sd1 <<< w;
        ok = t < bnd;
      end
      if (ok || !st) r = t[63:0] & m;
      else begin r = lim; f = 1'b1; end
    end else begin
      if (st && v != 0) begin r = lim; f = 1'b1; end
    end
  endfunction

  task automatic run(input string tag, input int md, input int ws, input bit rn,
                     input bit st, input logic [63:0] s, input int sh, input bit clr);
    logic [63:0] er;
    bit ef;
    @(negedge clk);
    mode_i = 2'(md); width_i = 2'(ws); round_en_i = rn; sat_en_i = st;
    elem_i = s; shamt_i = 8'(sh); sticky_clr_i = clr;
    model(md, ws, rn, st, s, sh, er, ef);
    #1;
    checks++;
    if (result_o !== er || sat_o !== ef) begin
      errors++;
      $display("FAIL %s md=%0d ws=%0d rn=%0d st=%0d src=%h sh=%0d: result=%h sat=%0b expected result=%h sat=%0b",
               tag, md, ws, rn, st, s, sh, result_o, sat_o, er, ef);
    end
    checks++;
    if (sticky_o !== exp_sticky) begin
      errors++;
      $display("FAIL R10 sticky=%0b expected %0b", sticky_o, exp_sticky);
    end
    @(posedge clk);
    exp_sticky = (exp_sticky & !clr) | ef;
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired: done=0 expected done=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #20;
    checks++;
    if (sticky_o !== 1'b0) begin
      errors++;
      $display("FAIL R10 reset sticky=%0b expected 0", sticky_o);
    end
    @(negedge clk);
    rst_n = 1'b1;
    // R1 width select and upper bits ignored
    run("R1", 1, 0, 0, 0, 64'hFFFF_FFFF_FFFF_FFA5, 0, 0);
    run("R1", 0, 1, 0, 0, 64'h1234_5678_9ABC_8001, 0, 0);
    run("R1", 1, 2, 0, 0, 64'hDEAD_BEEF_CAFE_F00D, 4, 0);
    // R2 exact left shifts
    run("R2", 0, 1, 0, 1, 64'h0012, 4, 0);
    run("R2", 1, 3, 0, 1, 64'h1, 63, 0);
    run("R2", 0, 0, 0, 1, 64'hC0, 1, 0);
    run("R2", 3, 0, 0, 1, 64'h7F, 1, 0);
    // R3 plain right shifts
    run("R3", 0, 0, 0, 0, 64'h80, -3, 0);
    run("R3", 0, 0, 0, 0, 64'h80, -8, 0);
    run("R3", 1, 0, 0, 0, 64'h80, -3, 0);
    run("R3", 1, 0, 0, 0, 64'h80, -8, 0);
    run("R3", 0, 3, 0, 0, 64'h8000_0000_0000_0000, -64, 0);
    // R4 rounding right shifts
    run("R4", 0, 0, 1, 0, 64'h05, -1, 0);
    run("R4", 0, 0, 1, 0, 64'hFB, -1, 0);
    run("R4", 0, 0, 1, 0, 64'h80, -7, 0);
    run("R4", 0, 0, 1, 0, 64'h80, -8, 0);
    run("R4", 1, 0, 1, 0, 64'h80, -8, 0);
    run("R4", 1, 0, 1, 0, 64'h80, -9, 0);
    run("R4", 1, 3, 1, 0, 64'hFFFF_FFFF_FFFF_FFFF, -64, 0);
    run("R4", 0, 3, 1, 0, 64'hFFFF_FFFF_FFFF_FFFF, -64, 0);
    // R5 overflow without saturation
    run("R5", 0, 0, 0, 0, 64'h40, 1, 0);
    run("R5", 1, 0, 0, 0, 64'hFF, 8, 0);
    run("R5", 1, 1, 0, 0, 64'hABCD, 9, 0);
    // R6 signed saturation
    run("R6", 0, 0, 0, 1, 64'h40, 1, 0);
    run("R6", 0, 0, 0, 1, 64'hC0, 2, 0);
    run("R6", 0, 3, 0, 1, 64'h1, 100, 0);
    run("R6", 0, 3, 0, 1, 64'h0, 100, 0);
    run("R6", 0, 2, 0, 1, 64'h8000_0000, 32, 0);
    // R7 unsigned saturation
    run("R7", 1, 1, 0, 1, 64'h8000, 1, 0);
    run("R7", 1, 2, 0, 1, 64'h1, 32, 0);
    // R8 signed to unsigned
    run("R8", 2, 0, 0, 1, 64'h80, -1, 0);
    run("R8", 2, 0, 0, 1, 64'h7F, 1, 0);
    run("R8", 2, 0, 0, 1, 64'h7F, 2, 0);
    run("R8", 2, 0, 0, 0, 64'h80, -1, 0);
    run("R8", 2, 3, 1, 1, 64'h8000_0000_0000_0000, 0, 0);
    // R9 amount extremes
    run("R9", 0, 0, 0, 0, 64'h80, -128, 0);
    run("R9", 1, 3, 1, 0, 64'hFFFF_FFFF_FFFF_FFFF, -128, 0);
    run("R9", 0, 3, 0, 1, 64'h1, 127, 0);
    // R10 sticky behaviour
    run("R10", 0, 0, 0, 0, 64'h1, 0, 1);
    run("R10", 1, 0, 0, 1, 64'hFF, 1, 0);
    run("R10", 1, 0, 0, 0, 64'h1, 0, 0);
    run("R10", 1, 0, 0, 1, 64'hFF, 1, 1);
    run("R10", 1, 0, 0, 0, 64'h1, 0, 1);
    run("R10", 1, 0, 0, 0, 64'h1, 0, 0);
    // random mix across R1 to R10 rules
    for (int i = 0; i < 3000; i++) begin
      logic [63:0] s;
      int sh;
      s = {$urandom, $urandom};
      if ($urandom % 4 == 0) s = s >> ($urandom % 64);
      sh = $signed(8'($urandom));
      if ($urandom % 2 == 0) sh = ($urandom % 140) - 70;
      if (sh > 127) sh = 127;
      run("R2", int'($urandom % 4), int'($urandom % 4), 1'($urandom), 1'($urandom),
          s, sh, ($urandom % 8) == 0);
    end
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule